// File: doc/BRIEF.md
# Column-Write Single-Port RAM

This block is a single-port RAM with one address bus, one write-data bus, a write mask and one read-data bus. An all-zero mask makes the cycle a read of the addressed word. Any nonzero mask makes it a write. The mask splits each word into equal columns, and the write changes only the columns whose mask bit is set. The rest of the word keeps its stored bits. Words are plain bit vectors, so the block suits integer and fixed-point data.

A single enumerated parameter sets the read timing. There are three choices:
- Registered read with new data on a write cycle: the output shows the word as it is after the write.
- Registered read with old data on a write cycle: the output shows the word as it was before the write.
- Combinational read: the output follows the addressed word with no cycle of delay.

Every word starts at a parameter value. Reset clears only the output register. It never clears the storage array.

Top module: `colwr_sp_ram`

## Requirements
- R1: In the registered modes, a cycle with `wr_mask` all zero reads the word at `addr`, and `rd_data` shows that word after the next rising clock edge.
- R2: A nonzero `wr_mask` writes the addressed word column by column. Columns are `DATA_W/MASK_W` bits wide. Mask bit i selects bits `[i*COL_W +: COL_W]`, with column 0 at the least significant end. Columns whose mask bit is clear keep their stored value.
- R3: With 16-bit words and a 4-bit mask, writing 0x03D4 with mask 0b0110 into a zero word at address 25 stores 0x03D0. In new-data mode, 0x03D0 also appears on `rd_data` after that edge.
- R4: In new-data mode (`RD_SYNC_NEW`), the output after a write edge is the merged word. This is the selected columns from `wr_data` plus the unselected columns from storage.
- R5: In old-data mode (`RD_SYNC_OLD`), the output after a write edge is the word as it was before the write.
- R6: In combinational mode (`RD_ASYNC`), `rd_data` equals the stored word at the present `addr` within the same cycle. Right after a write edge, it already shows the written word.
- R7: Every word holds `INIT_WORD` until it is first written.
- R8: With `rst_n` low at a rising edge, the output register of the registered modes becomes zero. Reset leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| addr | input | ADDR_W | Word address for both read and write (2 to 31 bits) |
| wr_mask | input | MASK_W | Column write mask; all zero means read |
| wr_data | input | DATA_W | Data for the selected columns |
| rd_data | output | DATA_W | Read data, timed by `RD_MODE` |

## Verification
A write and a read of the same word happen together on every write cycle. The output must report either the merged word or the word before the write, so the two always overlap. The bench drives one stimulus stream into three instances, one per read mode. It checks each output against a reference array that applies the same column mask. The checks run twice per cycle: before the edge, which finds the combinational output still on the old word, and after it. A directed part repeats writes to one address and follows them with reads. A random part keeps addresses in a narrow range, so that partial-mask writes often land on words already written.

// File: rtl/colwr_pkg.sv
// Package: shared types for the column-write single-port RAM.
// Assumes: nothing; it holds declarations only.
package colwr_pkg;

    // Read timing choices for the RAM output.
    typedef enum logic [1:0] {
        RD_SYNC_NEW = 2'd0,   // registered read, post-write word on a write cycle
        RD_SYNC_OLD = 2'd1,   // registered read, pre-write word on a write cycle
        RD_ASYNC    = 2'd2    // combinational read of the addressed word
    } rd_mode_e;

endpackage

// File: rtl/colwr_col_merge.sv
// Module: colwr_col_merge
// Builds the word a write would leave behind. For each column, it takes the
// bits of wr_data when the column's mask bit is set and the bits of old_word
// when it is clear.
// Assumes: DATA_W is an exact multiple of MASK_W, and column 0 is at the LSBs.
module colwr_col_merge #(
    parameter int DATA_W = 16,
    parameter int MASK_W = 4
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [MASK_W-1:0] wr_mask,
    output logic [DATA_W-1:0] merged
);
    localparam int COL_W = DATA_W / MASK_W;

    for (genvar c = 0; c < MASK_W; c++) begin : g_col
        // Choose this column's source from its mask bit.
        assign merged[c*COL_W +: COL_W] = wr_mask[c] ? wr_data[c*COL_W +: COL_W]
                                                     : old_word[c*COL_W +: COL_W];
    end
endmodule

// File: rtl/colwr_store.sv
// Module: colwr_store
// The word array. The addressed word is always visible on cur_word. When
// wr_en is high, the pre-merged word is written at the rising edge. No
// reset ever clears the array. Every word starts at INIT_WORD.
// Assumes: wr_word is already column-merged; wr_mask and wr_data are inputs
// only so the column checks can see them.
module colwr_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int MASK_W = 4,
    parameter logic [DATA_W-1:0] INIT_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_word,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cur_word
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int COL_W = DATA_W / MASK_W;

    logic [DATA_W-1:0] mem [DEPTH] = '{default: INIT_WORD};

    // Write the merged word into the array on a write cycle.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_word;
        end
    end

    // Combinational view of the addressed word.
    assign cur_word = mem[addr];

    for (genvar c = 0; c < MASK_W; c++) begin : g_chk
        // R2: a column left out of the mask keeps its stored bits
        assert_keep_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_mask[c]) |=>
            mem[$past(addr)][c*COL_W +: COL_W] == $past(cur_word[c*COL_W +: COL_W]));
        // R2: a column in the mask takes the incoming bits
        assert_take_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
            wr_mask[c] |=>
            mem[$past(addr)][c*COL_W +: COL_W] == $past(wr_data[c*COL_W +: COL_W]));
    end
endmodule

// File: rtl/colwr_sp_ram.sv
// Module: colwr_sp_ram
// Single-port RAM with a column write mask. A zero mask reads the word; a
// nonzero mask writes the selected columns. RD_MODE sets the output timing:
// registered with the new word, registered with the old word, or
// combinational.
// Assumes: ADDR_W is between 2 and 31, and MASK_W divides DATA_W exactly.
module colwr_sp_ram
    import colwr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int MASK_W = 4,
    parameter logic [DATA_W-1:0] INIT_WORD = '0,
    parameter rd_mode_e RD_MODE = RD_SYNC_NEW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [MASK_W-1:0] wr_mask,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    logic              wr_en;
    logic [DATA_W-1:0] cur_word;
    logic [DATA_W-1:0] merged;

    // Any mask bit set turns the cycle into a write.
    assign wr_en = |wr_mask;

    colwr_col_merge #(
        .DATA_W (DATA_W),
        .MASK_W (MASK_W)
    ) merge_i (
        .old_word (cur_word),
        .wr_data  (wr_data),
        .wr_mask  (wr_mask),
        .merged   (merged)
    );

    colwr_store #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .MASK_W    (MASK_W),
        .INIT_WORD (INIT_WORD)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_word  (merged),
        .wr_mask  (wr_mask),
        .wr_data  (wr_data),
        .cur_word (cur_word)
    );

    if (RD_MODE == RD_ASYNC) begin : g_async
        // Output follows the array with no register.
        assign rd_data = cur_word;

        // R6: right after a full-mask write, the same address shows the new word
        assert_async_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_mask == '1) |=> (addr != $past(addr) || rd_data == $past(wr_data)));
    end else begin : g_sync
        logic [DATA_W-1:0] rd_q;
        logic [DATA_W-1:0] next_word;

        // Pick the merged word only in new-data mode on a write cycle.
        assign next_word = (RD_MODE == RD_SYNC_NEW && wr_en) ? merged : cur_word;

        // Output register, cleared by the synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else begin
                rd_q <= next_word;
            end
        end

        assign rd_data = rd_q;

        // R8: reset at an edge leaves a zero output
        assert_rst_clear_R8: assert property (@(posedge clk)
            !rst_n |=> rd_data == '0);
        // R1: a full write followed by a read of that word returns the data
        assert_read_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_mask == '1) ##1 (!wr_en && addr == $past(addr)) |=>
            rd_data == $past(wr_data, 2));

        if (RD_MODE == RD_SYNC_NEW) begin : g_new
            // R4: the word shown on a write matches what a later read returns
            assert_new_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en ##1 (!wr_en && addr == $past(addr)) |=>
                rd_data == $past(rd_data));
        end else begin : g_old
            // R5: a second write to a word shows what the first one stored
            assert_old_prev_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_mask == '1) ##1 (wr_en && addr == $past(addr)) |=>
                rd_data == $past(wr_data, 2));
        end
    end
endmodule

// File: tb/colwr_sp_ram_tb.sv
// Bench: drives one stimulus stream into three instances, one per read mode,
// and compares every output against a reference array with column masking.
`timescale 1ns/1ps
module colwr_sp_ram_tb_top;
    import colwr_pkg::*;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int MW = 4;
    localparam int CW = DW / MW;
    localparam logic [DW-1:0] INIT = 16'h5A3C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [MW-1:0] wr_mask = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_new, rd_old, rd_async;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DW-1:0] ref_mem [1 << AW];

    always #2.5 clk = ~clk;

    colwr_sp_ram #(.ADDR_W(AW), .DATA_W(DW), .MASK_W(MW), .INIT_WORD(INIT),
                   .RD_MODE(RD_SYNC_NEW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_mask(wr_mask),
        .wr_data(wr_data), .rd_data(rd_new));

    colwr_sp_ram #(.ADDR_W(AW), .DATA_W(DW), .MASK_W(MW), .INIT_WORD(INIT),
                   .RD_MODE(RD_SYNC_OLD)) dut_old_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_mask(wr_mask),
        .wr_data(wr_data), .rd_data(rd_old));

    colwr_sp_ram #(.ADDR_W(AW), .DATA_W(DW), .MASK_W(MW), .INIT_WORD(INIT),
                   .RD_MODE(RD_ASYNC)) dut_async_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_mask(wr_mask),
        .wr_data(wr_data), .rd_data(rd_async));

    // Column merge computed by the bench itself.
    function automatic logic [DW-1:0] exp_merge(input logic [DW-1:0] w,
                                                input logic [MW-1:0] m,
                                                input logic [DW-1:0] d);
        logic [DW-1:0] r = w;
        for (int c = 0; c < MW; c++) begin
            if (m[c]) r[c*CW +: CW] = d[c*CW +: CW];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check before and after the rising edge.
    task automatic step(input logic [AW-1:0] a, input logic [MW-1:0] m,
                        input logic [DW-1:0] d);
        logic [DW-1:0] old_w, new_w;
        @(negedge clk);
        addr = a; wr_mask = m; wr_data = d;
        #1;
        old_w = ref_mem[a];
        new_w = (m != '0) ? exp_merge(old_w, m, d) : old_w;
        chk("R6 async before edge", rd_async, old_w);
        @(posedge clk);
        ref_mem[a] = new_w;
        #1;
        chk((m != '0) ? "R4 new-data write" : "R1 new-mode read", rd_new, new_w);
        chk((m != '0) ? "R5 old-data write" : "R1 old-mode read", rd_old, old_w);
        chk("R6 async after edge", rd_async, new_w);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_mask = '0;
        repeat (2) @(posedge clk);
        #1;
        chk("R8 reset new-mode output", rd_new, '0);
        chk("R8 reset old-mode output", rd_old, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = INIT;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R8 reset state new", rd_new, '0);
        chk("R8 reset state old", rd_old, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: untouched words return the initial value
        step(6'd40, 4'h0, 16'h0);
        chk("R7 initial word", rd_new, INIT);
        step(6'd63, 4'h0, 16'h0);
        chk("R7 initial word last", rd_old, INIT);

        // R3: documented column case, word cleared first
        step(6'd25, 4'hF, 16'h0000);
        step(6'd25, 4'b0110, 16'd980);
        chk("R3 new-data output", rd_new, 16'd976);
        chk("R3 old-data output", rd_old, 16'd0);
        step(6'd25, 4'h0, 16'h0);
        chk("R3 stored word", rd_new, 16'd976);

        // R2: one column at a time on the same word
        step(6'd3, 4'hF, 16'hFFFF);
        for (int c = 0; c < MW; c++) step(6'd3, 4'(1 << c), 16'h0000);
        step(6'd3, 4'h0, 16'h0);
        chk("R2 every column cleared", rd_old, 16'h0000);
        step(6'd3, 4'b1001, 16'hA5C3);
        step(6'd3, 4'h0, 16'h0);
        chk("R2 outer columns only", rd_new, 16'hA003);

        // R5/R4: back-to-back writes to one word
        step(6'd9, 4'hF, 16'h1234);
        step(6'd9, 4'hF, 16'hBEEF);
        chk("R5 old word on second write", rd_old, 16'h1234);
        chk("R4 new word on second write", rd_new, 16'hBEEF);

        // R8: reset keeps array contents
        pulse_reset();
        step(6'd9, 4'h0, 16'h0);
        chk("R8 array kept through reset", rd_new, 16'hBEEF);
        step(6'd25, 4'h0, 16'h0);
        chk("R8 array kept through reset", rd_old, 16'd976);

        // Random mix over a narrow address range.
        for (int n = 0; n < 400; n++) begin
            logic [MW-1:0] m;
            m = ($urandom_range(0, 3) == 0) ? '0 : MW'($urandom);
            step(AW'($urandom_range(0, 15)), m, DW'($urandom));
        end
        pulse_reset();
        for (int i = 0; i < 16; i++) step(AW'(i), 4'h0, 16'h0);
        step(6'd40, 4'h0, 16'h0);
        chk("R7 untouched after random run", rd_async, INIT);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule